// File: doc/BRIEF.md
# Four-Plane Planar Write Unit

This block turns a CPU byte write into a window of video memory into byte updates across four bit planes, as used by 16-colour planar display modes. Every plane is a separate on-chip byte array indexed by the same offset. On an accepted write the unit first captures the current byte of all four planes at that offset. In the following cycle it computes a new byte for each plane and stores it back.

The new byte for a plane is built from one source bit per plane, which is either the plane's set/reset bit or the plane's CPU data bit. That bit is spread across the byte and combined with the captured byte by one of four logic functions. The bit mask limits which bit positions can change. A per-plane enable from the map mask decides which planes are rewritten at all. A debug port returns the four plane bytes at any offset so the contents can be inspected.

Top module: `vga_plane_writer`

## Requirements
- R1: After reset, busy_o is low and every byte of every plane reads as 0x00 through the debug port.
- R2: A write is taken only when addr_i lies in WIN_BASE to WIN_BASE+2^OFS_W-1 (default 0xA0000 to 0xA00FF), and it targets offset addr_i-WIN_BASE. A write outside that range raises no busy and changes no plane byte.
- R3: An accepted write drives busy_o high in the next cycle for exactly one cycle. The new plane bytes are visible on the debug port once busy_o falls. A wr_i that arrives while busy_o is high is ignored.
- R4: Plane n (n = 0..3) is rewritten only when map_mask_i bit n is 1. Otherwise its byte keeps its old value.
- R5: With wmode_i = 0, the source bit of plane n is set_reset_i bit n.
- R6: With wmode_i = 2, the source bit of plane n is data_i bit n.
- R7: Let S be the source bit repeated over all eight bits, L the captured byte and M = bit_mask_i. Then func_i = 0 gives (L & ~M) | (S & M), func_i = 1 gives L & (S | ~M), func_i = 2 gives L | (S & M), and func_i = 3 gives L ^ (S & M). Bit positions where M is 0 always keep L.
- R8: With wmode_i = 1, every enabled plane gets its captured byte back, so no plane byte changes.
- R9: With wmode_i = 3, the result is the same as with wmode_i = 0 for the same other inputs.
- R10: dbg_data_o carries the byte of plane n at dbg_ofs_i in bits [8n+7:8n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | CPU byte address |
| data_i | input | 8 | CPU data byte |
| wmode_i | input | 2 | Write mode |
| func_i | input | 2 | Logic function: 0 replace, 1 AND, 2 OR, 3 XOR |
| set_reset_i | input | 4 | Set/reset bit for each plane |
| bit_mask_i | input | 8 | Bit positions that may change |
| map_mask_i | input | 4 | Enable for each plane |
| busy_o | output | 1 | Write in progress; new writes are ignored |
| dbg_ofs_i | input | OFS_W | Debug read offset |
| dbg_data_o | output | 32 | Four plane bytes at dbg_ofs_i |

## Verification
Writes are first tried with the mask fully open and with only half of it open. These runs show whether masked bits really keep the captured byte. Each of the four functions is run with the source taken from set/reset and then from CPU data, using source patterns that differ from plane to plane. A swapped plane index or a source taken from the wrong input therefore shows up as a wrong byte. Partial map masks and mode 1 show which planes must stay untouched, and mode 3 is compared with the model for mode 0. Writes just outside both ends of the window, writes issued during busy, and a long run of pseudo-random writes compared against a behavioural model over the whole window cover the remaining cases.

// File: rtl/vga_wr_pkg.sv
package vga_wr_pkg;
  localparam int NPLANES = 4;
  localparam int BYTE_W  = 8;

  typedef enum logic [1:0] {
    WM_SRC_SR   = 2'd0,
    WM_LATCH    = 2'd1,
    WM_SRC_DATA = 2'd2,
    WM_SR_ALT   = 2'd3
  } wmode_e;

  typedef enum logic [1:0] {
    FN_REPL = 2'd0,
    FN_AND  = 2'd1,
    FN_OR   = 2'd2,
    FN_XOR  = 2'd3
  } alu_fn_e;

  typedef struct packed {
    wmode_e                mode;
    alu_fn_e               fn;
    logic [BYTE_W-1:0]     mask;
    logic [NPLANES-1:0]    sr;
    logic [BYTE_W-1:0]     data;
    logic [NPLANES-1:0]    map;
  } wr_cfg_t;
endpackage

// File: rtl/vga_wr_ctrl.sv
module vga_wr_ctrl #(
  parameter int          ADDR_W   = 20,
  parameter int          OFS_W    = 8,
  parameter logic [19:0] WIN_BASE = 20'hA0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic [OFS_W-1:0]  ofs_o
);
  localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(WIN_BASE);
  localparam logic [ADDR_W:0] WIN_HI = WIN_LO + (ADDR_W+1)'(2 ** OFS_W);

  logic [ADDR_W:0] addr_x;
  logic [ADDR_W:0] diff;
  logic            in_win;
  logic            busy_q;

  assign addr_x   = {1'b0, addr_i};
  assign diff     = addr_x - WIN_LO;
  assign in_win   = (addr_x >= WIN_LO) && (addr_x < WIN_HI);
  assign ofs_o    = diff[OFS_W-1:0];
  assign accept_o = wr_i && !busy_q && in_win;
  assign busy_o   = busy_q;

  // busy covers the single modify/write-back cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= accept_o;
  end
endmodule

// File: rtl/vga_plane_alu.sv
module vga_plane_alu
  import vga_wr_pkg::*;
(
  input  logic [BYTE_W-1:0] latch_i,
  input  logic              src_bit_i,
  input  wmode_e            mode_i,
  input  alu_fn_e           fn_i,
  input  logic [BYTE_W-1:0] mask_i,
  output logic [BYTE_W-1:0] res_o
);
  logic [BYTE_W-1:0] fill;
  logic [BYTE_W-1:0] op;

  always_comb begin
    fill = {BYTE_W{src_bit_i}};
    op   = fill & mask_i;
    unique case (fn_i)
      FN_REPL: res_o = (latch_i & ~mask_i) | op;
      FN_AND:  res_o = latch_i & (fill | ~mask_i);
      FN_OR:   res_o = latch_i | op;
      FN_XOR:  res_o = latch_i ^ op;
      default: res_o = latch_i;
    endcase
    if (mode_i == WM_LATCH) res_o = latch_i;
  end
endmodule

// File: rtl/vga_plane_lane.sv
module vga_plane_lane
  import vga_wr_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [OFS_W-1:0]  ld_ofs_i,
  input  logic              we_i,
  input  logic [OFS_W-1:0]  wb_ofs_i,
  input  logic              src_bit_i,
  input  wmode_e            mode_i,
  input  alu_fn_e           fn_i,
  input  logic [BYTE_W-1:0] mask_i,
  input  logic [OFS_W-1:0]  dbg_ofs_i,
  output logic [BYTE_W-1:0] dbg_o
);
  localparam int DEPTH = 2 ** OFS_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] latch_q;
  logic [BYTE_W-1:0] res;

  vga_plane_alu u_alu (
    .latch_i  (latch_q),
    .src_bit_i(src_bit_i),
    .mode_i   (mode_i),
    .fn_i     (fn_i),
    .mask_i   (mask_i),
    .res_o    (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (ld_i) latch_q <= mem[ld_ofs_i];
      if (we_i) mem[wb_ofs_i] <= res;
    end
  end

  assign dbg_o = mem[dbg_ofs_i];
endmodule

// File: rtl/vga_plane_writer.sv
module vga_plane_writer
  import vga_wr_pkg::*;
#(
  parameter int          ADDR_W   = 20,
  parameter int          OFS_W    = 8,
  parameter logic [19:0] WIN_BASE = 20'hA0000
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [BYTE_W-1:0]         data_i,
  input  logic [1:0]                wmode_i,
  input  logic [1:0]                func_i,
  input  logic [NPLANES-1:0]        set_reset_i,
  input  logic [BYTE_W-1:0]         bit_mask_i,
  input  logic [NPLANES-1:0]        map_mask_i,
  output logic                      busy_o,
  input  logic [OFS_W-1:0]          dbg_ofs_i,
  output logic [NPLANES*BYTE_W-1:0] dbg_data_o
);
  logic             accept;
  logic [OFS_W-1:0] ofs_in;
  logic [OFS_W-1:0] ofs_q;
  wr_cfg_t          cfg_q;

  vga_wr_ctrl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .WIN_BASE(WIN_BASE)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .accept_o(accept),
    .busy_o  (busy_o),
    .ofs_o   (ofs_in)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q <= '0;
      cfg_q <= '0;
    end else if (accept) begin
      ofs_q      <= ofs_in;
      cfg_q.mode <= wmode_e'(wmode_i);
      cfg_q.fn   <= alu_fn_e'(func_i);
      cfg_q.mask <= bit_mask_i;
      cfg_q.sr   <= set_reset_i;
      cfg_q.data <= data_i;
      cfg_q.map  <= map_mask_i;
    end
  end

  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    logic src_bit;
    assign src_bit = (cfg_q.mode == WM_SRC_DATA) ? cfg_q.data[p] : cfg_q.sr[p];

    vga_plane_lane #(.OFS_W(OFS_W)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ld_i     (accept),
      .ld_ofs_i (ofs_in),
      .we_i     (busy_o && cfg_q.map[p]),
      .wb_ofs_i (ofs_q),
      .src_bit_i(src_bit),
      .mode_i   (cfg_q.mode),
      .fn_i     (cfg_q.fn),
      .mask_i   (cfg_q.mask),
      .dbg_ofs_i(dbg_ofs_i),
      .dbg_o    (dbg_data_o[p*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/vga_plane_writer_chk.sv
module vga_plane_writer_chk #(
  parameter int          ADDR_W   = 20,
  parameter int          OFS_W    = 8,
  parameter logic [19:0] WIN_BASE = 20'hA0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              busy_o,
  input logic [OFS_W-1:0]  dbg_ofs_i,
  input logic [31:0]       dbg_data_o
);
  localparam longint LO = longint'(WIN_BASE);
  localparam longint HI = LO + (longint'(1) << OFS_W);

  logic outside;
  assign outside = (longint'(addr_i) < LO) || (longint'(addr_i) >= HI);

  a_r3_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_o && !outside) |=> busy_o);

  a_r3_busy_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);

  a_r2_outside_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_o && outside) |=> !busy_o);

  a_r3_mem_still_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(busy_o) && $stable(dbg_ofs_i)) |-> $stable(dbg_data_o));
endmodule

bind vga_plane_writer vga_plane_writer_chk #(
  .ADDR_W(ADDR_W), .OFS_W(OFS_W), .WIN_BASE(WIN_BASE)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .busy_o    (busy_o),
  .dbg_ofs_i (dbg_ofs_i),
  .dbg_data_o(dbg_data_o)
);

// File: tb/sim_vga_plane_writer.sv
`timescale 1ns/1ps
module sim_vga_plane_writer;
  localparam int ADDR_W = 20;
  localparam int OFS_W  = 8;
  localparam int DEPTH  = 256;
  localparam int BASE   = 'hA0000;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [7:0]        data_i = '0;
  logic [1:0]        wmode_i = '0;
  logic [1:0]        func_i = '0;
  logic [3:0]        set_reset_i = '0;
  logic [7:0]        bit_mask_i = '0;
  logic [3:0]        map_mask_i = '0;
  logic              busy_o;
  logic [OFS_W-1:0]  dbg_ofs_i = '0;
  logic [31:0]       dbg_data_o;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] ref_mem [4][DEPTH];

  always #2 clk_i = ~clk_i;

  vga_plane_writer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .data_i(data_i),
    .wmode_i(wmode_i), .func_i(func_i), .set_reset_i(set_reset_i),
    .bit_mask_i(bit_mask_i), .map_mask_i(map_mask_i), .busy_o(busy_o),
    .dbg_ofs_i(dbg_ofs_i), .dbg_data_o(dbg_data_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // bitwise model of one plane update
  function automatic logic [7:0] model(input logic [7:0] lat, input int mode, input int fn,
                                       input logic [7:0] msk, input logic [3:0] sr,
                                       input logic [7:0] dat, input int p);
    logic [7:0] r;
    logic b;
    b = (mode == 2) ? dat[p] : sr[p];
    for (int i = 0; i < 8; i++) begin
      if (mode == 1 || !msk[i]) r[i] = lat[i];
      else if (fn == 0) r[i] = b;
      else if (fn == 1) r[i] = lat[i] & b;
      else if (fn == 2) r[i] = lat[i] | b;
      else r[i] = lat[i] ^ b;
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_word(input int o);
    return {ref_mem[3][o], ref_mem[2][o], ref_mem[1][o], ref_mem[0][o]};
  endfunction

  task automatic do_wr(input int addr, input int mode, input int fn, input logic [7:0] msk,
                       input logic [3:0] sr, input logic [7:0] dat, input logic [3:0] mp,
                       input string req);
    bit inwin;
    int o;
    inwin = (addr >= BASE) && (addr < BASE + DEPTH);
    o = addr - BASE;
    @(negedge clk_i);
    addr_i = addr[ADDR_W-1:0]; wmode_i = mode[1:0]; func_i = fn[1:0];
    bit_mask_i = msk; set_reset_i = sr; data_i = dat; map_mask_i = mp; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
    chk(busy_o == inwin, {req, " R3 busy after accept"}, 32'(busy_o), 32'(inwin));
    if (inwin) begin
      for (int p = 0; p < 4; p++)
        if (mp[p]) ref_mem[p][o] = model(ref_mem[p][o], mode, fn, msk, sr, dat, p);
      dbg_ofs_i = o[OFS_W-1:0];
    end
    @(negedge clk_i);
    chk(busy_o == 1'b0, {req, " R3 busy single cycle"}, 32'(busy_o), 32'd0);
    chk(dbg_data_o == ref_word(int'(dbg_ofs_i)), req, dbg_data_o, ref_word(int'(dbg_ofs_i)));
  endtask

  task automatic scan(input string req);
    for (int o = 0; o < DEPTH; o++) begin
      dbg_ofs_i = o[OFS_W-1:0];
      #1;
      chk(dbg_data_o == ref_word(o), req, dbg_data_o, ref_word(o));
    end
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++) for (int o = 0; o < DEPTH; o++) ref_mem[p][o] = 8'h00;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R1 busy after reset", 32'(busy_o), 32'd0);
    scan("R1 R10 zero after reset");

    // R6 R7 R10: data-sourced replace, full mask, distinct plane patterns
    do_wr(BASE + 5, 2, 0, 8'hFF, 4'h0, 8'h05, 4'hF, "R6 R10 mode2 replace");
    do_wr(BASE + 6, 2, 0, 8'hFF, 4'h0, 8'h0A, 4'hF, "R6 mode2 replace alt");
    // R5 R7: set/reset replace, half mask
    do_wr(BASE + 5, 0, 0, 8'h0F, 4'h6, 8'hFF, 4'hF, "R5 R7 mode0 replace half mask");
    do_wr(BASE + 5, 0, 1, 8'h3C, 4'h9, 8'h00, 4'hF, "R5 R7 mode0 AND");
    do_wr(BASE + 6, 0, 2, 8'hA5, 4'h3, 8'h00, 4'hF, "R5 R7 mode0 OR");
    do_wr(BASE + 6, 0, 3, 8'hF0, 4'hC, 8'h00, 4'hF, "R5 R7 mode0 XOR");
    do_wr(BASE + 5, 2, 1, 8'hC3, 4'hF, 8'h03, 4'hF, "R6 R7 mode2 AND");
    do_wr(BASE + 5, 2, 2, 8'h18, 4'h0, 8'h0C, 4'hF, "R6 R7 mode2 OR");
    do_wr(BASE + 6, 2, 3, 8'hFF, 4'h0, 8'h09, 4'hF, "R6 R7 mode2 XOR");
    // R4: partial map masks
    do_wr(BASE + 7, 2, 0, 8'hFF, 4'h0, 8'h0F, 4'h5, "R4 map mask 0101");
    do_wr(BASE + 7, 0, 3, 8'hFF, 4'hF, 8'h00, 4'h8, "R4 map mask 1000");
    do_wr(BASE + 7, 0, 0, 8'hFF, 4'hF, 8'h00, 4'h0, "R4 map mask none");
    // R8: latch passthrough
    do_wr(BASE + 5, 1, 3, 8'hFF, 4'hF, 8'hFF, 4'hF, "R8 mode1 no change");
    // R9: mode 3 like mode 0
    do_wr(BASE + 6, 3, 3, 8'h0F, 4'h5, 8'h00, 4'hF, "R9 mode3 XOR");
    do_wr(BASE + 6, 3, 0, 8'hF0, 4'hA, 8'h00, 4'hF, "R9 mode3 replace");
    // R2: window edges
    do_wr(BASE + DEPTH - 1, 2, 0, 8'hFF, 4'h0, 8'h0F, 4'hF, "R2 last offset");
    do_wr(BASE, 2, 0, 8'hFF, 4'h0, 8'h0F, 4'hF, "R2 first offset");
    do_wr(BASE - 1, 2, 0, 8'hFF, 4'h0, 8'h06, 4'hF, "R2 below window");
    do_wr(BASE + DEPTH, 2, 0, 8'hFF, 4'h0, 8'h06, 4'hF, "R2 above window");
    scan("R2 window untouched outside");

    // R3: second write during busy is ignored
    @(negedge clk_i);
    addr_i = ADDR_W'(BASE + 20); wmode_i = 2'd2; func_i = 2'd0; bit_mask_i = 8'hFF;
    data_i = 8'h0F; map_mask_i = 4'hF; wr_i = 1'b1;
    @(negedge clk_i);
    for (int p = 0; p < 4; p++) ref_mem[p][20] = 8'hFF;
    addr_i = ADDR_W'(BASE + 21);
    chk(busy_o == 1'b1, "R3 busy during first write", 32'(busy_o), 32'd1);
    @(negedge clk_i);
    wr_i = 1'b0;
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R3 ignored write raised no busy", 32'(busy_o), 32'd0);
    scan("R3 write during busy ignored");

    // pseudo-random sweep against the model
    for (int k = 0; k < 400; k++) begin
      int a;
      a = BASE + int'($urandom_range(DEPTH - 1));
      do_wr(a, int'($urandom_range(3)), int'($urandom_range(3)), 8'($urandom),
            4'($urandom), 8'($urandom), 4'($urandom), "R7 random");
    end
    scan("R7 final contents");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule